// File: doc/BRIEF.md
# Harvard Fetch Address Generator and Memory Mapper

This block holds the instruction pointer of a small 16-bit Harvard-architecture controller and steers every program-side and data-side access to one of three single-port physical memories: flash, utility ROM and data SRAM. Each memory has one port, driven by whichever side owns it in a given cycle. The program space is a 64K x 16 word-addressed space. Flash sits at the bottom of it, utility ROM starts at 8000h and data SRAM is visible at A000h so that code can run from it.

The data space gives a separate view of the same memories: SRAM at 0000h, flash at 4000h and ROM at 8000h. The segment that code is currently running from belongs to the program side. A data access aimed at that segment reads zero, has no effect when it is a write, and raises a one-cycle conflict flag. Flash and ROM are read-only from the data side. Programming the flash is done elsewhere.

Fetches use a request/valid handshake with one cycle of memory latency. Three sources can load the pointer: a redirect input for branch and interrupt targets, a software write port, and the automatic increment after each fetch.

Top module: `harvard_fetch_map`

## Requirements
- R1: While reset is held and after it is released, the instruction pointer reads 8000h, and fetch_valid, d_rvalid and d_conflict are 0 until a request is made.
- R2: A fetch request in cycle t presents the word at the current pointer on fetch_instr with fetch_valid high in cycle t+1. The request also advances the pointer by exactly 1.
- R3: The pointer load priority is redirect first, then software write, then increment. The loaded value is the address used by the next fetch.
- R4: ip_rdata always shows the present pointer value.
- R5: Program decode maps flash to 0000h-3FFFh, ROM to 8000h-8FFFh and SRAM to A000h-A7FFh. A fetch from any other address returns 0000h.
- R6: Data decode maps SRAM to 0000h-07FFh, flash to 4000h-7FFFh and ROM to 8000h-8FFFh. A read returns its word with d_rvalid one cycle later, and a read of an unmapped address returns 0000h.
- R7: The executing segment is the segment decoded from the present pointer. A data access to that segment returns 0000h, leaves memory unchanged if it is a write, and sets d_conflict for exactly the following cycle.
- R8: A data write issues a memory write only to SRAM. A write to the flash or ROM window drives neither sram_we nor flash_en.
- R9: A memory serves at most one side per cycle. When the fetch owns a memory, its address is the one on that memory's port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch the word at the pointer |
| fetch_valid | output | 1 | fetch_instr is valid this cycle |
| fetch_instr | output | 16 | Fetched instruction word |
| ip_we | input | 1 | Software write to the pointer |
| ip_wdata | input | 16 | Value for software write |
| ip_rdata | output | 16 | Present pointer value |
| redir_valid | input | 1 | Branch or interrupt redirect |
| redir_addr | input | 16 | Redirect target |
| d_addr | input | 16 | Data-space word address |
| d_rd | input | 1 | Data read strobe |
| d_wr | input | 1 | Data write strobe |
| d_wdata | input | 16 | Data write value |
| d_rdata | output | 16 | Data read result |
| d_rvalid | output | 1 | d_rdata valid this cycle |
| d_conflict | output | 1 | Previous data access hit the executing segment |
| flash_addr | output | 14 | Flash word address |
| flash_en | output | 1 | Flash read enable |
| flash_rdata | input | 16 | Flash read data, one cycle after enable |
| rom_addr | output | 12 | ROM word address |
| rom_en | output | 1 | ROM read enable |
| rom_rdata | input | 16 | ROM read data, one cycle after enable |
| sram_addr | output | 11 | SRAM word address |
| sram_en | output | 1 | SRAM enable |
| sram_we | output | 1 | SRAM write enable |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, one cycle after enable |

## Verification
The assertions assume that the memories return data exactly one cycle after their enable, and that d_rd and d_wr are never raised together. The bench memory models keep the one-cycle return, and no stimulus step drives both data strobes at once. The assertions also assume that the redirect and software-write inputs stay low while the internal reset is still being released. For that reason the stimulus waits several cycles after reset before driving anything.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
  typedef enum logic [1:0] {
    SEG_NONE  = 2'd0,
    SEG_FLASH = 2'd1,
    SEG_ROM   = 2'd2,
    SEG_SRAM  = 2'd3
  } seg_e;
endpackage

// File: rtl/hfm_decode.sv
// Address window decoder; instantiated once per address space.
module hfm_decode
  import hfm_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] FLASH_BASE = '0,
  parameter int FLASH_WORDS = 16384,
  parameter logic [AW-1:0] ROM_BASE = '0,
  parameter int ROM_WORDS = 4096,
  parameter logic [AW-1:0] SRAM_BASE = '0,
  parameter int SRAM_WORDS = 2048
) (
  input  logic [AW-1:0] addr,
  output seg_e          seg,
  output logic [AW-1:0] off
);
  localparam logic [AW:0] F_LO = {1'b0, FLASH_BASE};
  localparam logic [AW:0] F_HI = F_LO + (AW+1)'(FLASH_WORDS);
  localparam logic [AW:0] R_LO = {1'b0, ROM_BASE};
  localparam logic [AW:0] R_HI = R_LO + (AW+1)'(ROM_WORDS);
  localparam logic [AW:0] S_LO = {1'b0, SRAM_BASE};
  localparam logic [AW:0] S_HI = S_LO + (AW+1)'(SRAM_WORDS);

  logic [AW:0] a_ext;

  always_comb begin
    a_ext = {1'b0, addr};
    seg   = SEG_NONE;
    off   = '0;
    if (a_ext >= F_LO && a_ext < F_HI) begin
      seg = SEG_FLASH;
      off = addr - FLASH_BASE;
    end else if (a_ext >= R_LO && a_ext < R_HI) begin
      seg = SEG_ROM;
      off = addr - ROM_BASE;
    end else if (a_ext >= S_LO && a_ext < S_HI) begin
      seg = SEG_SRAM;
      off = addr - SRAM_BASE;
    end
  end
endmodule

// File: rtl/hfm_ip.sv
// Instruction pointer: redirect > software write > increment.
module hfm_ip #(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_IP = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          redir,
  input  logic [AW-1:0] redir_addr,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_data,
  output logic [AW-1:0] ip
);
  logic [AW-1:0] ip_q, ip_d;
  logic          ip_en;

  always_comb begin
    ip_en = redir | sw_we | adv;
    ip_d  = ip_q;
    if (redir)      ip_d = redir_addr;
    else if (sw_we) ip_d = sw_data;
    else if (adv)   ip_d = ip_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ip_q <= RESET_IP;
    else if (ip_en) ip_q <= ip_d;
  end

  assign ip = ip_q;
endmodule

// File: rtl/hfm_route.sv
// Memory port steering, ownership check and read return path.
module hfm_route
  import hfm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int FW = 14,
  parameter int RW = 12,
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_req,
  input  seg_e          f_seg,
  input  logic [AW-1:0] f_off,
  input  logic          d_rd,
  input  logic          d_wr,
  input  seg_e          d_seg,
  input  logic [AW-1:0] d_off,
  input  logic [DW-1:0] d_wdata,
  output logic [FW-1:0] flash_addr,
  output logic          flash_en,
  input  logic [DW-1:0] flash_rdata,
  output logic [RW-1:0] rom_addr,
  output logic          rom_en,
  input  logic [DW-1:0] rom_rdata,
  output logic [SW-1:0] sram_addr,
  output logic          sram_en,
  output logic          sram_we,
  output logic [DW-1:0] sram_wdata,
  input  logic [DW-1:0] sram_rdata,
  output logic          fetch_valid,
  output logic [DW-1:0] fetch_instr,
  output logic          d_rvalid,
  output logic [DW-1:0] d_rdata,
  output logic          d_conflict
);
  logic d_any, clash, d_pass, d_rpass;
  logic f_fl, f_ro, f_sr;
  logic fv_q, dv_q, cf_q;
  seg_e fseg_q, dseg_q, dseg_d;

  function automatic logic [DW-1:0] pick(seg_e s, logic [DW-1:0] fl,
                                         logic [DW-1:0] ro, logic [DW-1:0] sr);
    case (s)
      SEG_FLASH: return fl;
      SEG_ROM:   return ro;
      SEG_SRAM:  return sr;
      default:   return '0;
    endcase
  endfunction

  always_comb begin
    d_any   = d_rd | d_wr;
    clash   = d_any && (d_seg != SEG_NONE) && (d_seg == f_seg);
    d_pass  = d_any && (d_seg != SEG_NONE) && !clash;
    d_rpass = d_pass && d_rd;
    f_fl    = f_req && (f_seg == SEG_FLASH);
    f_ro    = f_req && (f_seg == SEG_ROM);
    f_sr    = f_req && (f_seg == SEG_SRAM);

    flash_en   = f_fl || (d_rpass && d_seg == SEG_FLASH);
    flash_addr = f_fl ? f_off[FW-1:0] : d_off[FW-1:0];
    rom_en     = f_ro || (d_rpass && d_seg == SEG_ROM);
    rom_addr   = f_ro ? f_off[RW-1:0] : d_off[RW-1:0];
    sram_en    = f_sr || (d_pass && d_seg == SEG_SRAM);
    sram_we    = !f_sr && d_pass && d_wr && (d_seg == SEG_SRAM);
    sram_addr  = f_sr ? f_off[SW-1:0] : d_off[SW-1:0];
    sram_wdata = d_wdata;

    dseg_d = d_rpass ? d_seg : SEG_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fv_q   <= 1'b0;
      dv_q   <= 1'b0;
      cf_q   <= 1'b0;
      fseg_q <= SEG_NONE;
      dseg_q <= SEG_NONE;
    end else begin
      fv_q   <= f_req;
      dv_q   <= d_rd;
      cf_q   <= clash;
      dseg_q <= dseg_d;
      if (f_req) fseg_q <= f_seg;
    end
  end

  assign fetch_valid = fv_q;
  assign fetch_instr = fv_q ? pick(fseg_q, flash_rdata, rom_rdata, sram_rdata) : '0;
  assign d_rvalid    = dv_q;
  assign d_rdata     = pick(dseg_q, flash_rdata, rom_rdata, sram_rdata);
  assign d_conflict  = cf_q;
endmodule

// File: rtl/harvard_fetch_map.sv
module harvard_fetch_map
  import hfm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int FLASH_WORDS = 16384,
  parameter int ROM_WORDS   = 4096,
  parameter int SRAM_WORDS  = 2048,
  parameter logic [AW-1:0] RESET_IP    = 16'h8000,
  parameter logic [AW-1:0] P_ROM_BASE  = 16'h8000,
  parameter logic [AW-1:0] P_SRAM_BASE = 16'hA000,
  parameter logic [AW-1:0] D_SRAM_BASE = 16'h0000,
  parameter logic [AW-1:0] D_FLASH_BASE = 16'h4000,
  parameter logic [AW-1:0] D_ROM_BASE  = 16'h8000,
  localparam int FW = $clog2(FLASH_WORDS),
  localparam int RW = $clog2(ROM_WORDS),
  localparam int SW = $clog2(SRAM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  output logic          fetch_valid,
  output logic [DW-1:0] fetch_instr,
  input  logic          ip_we,
  input  logic [AW-1:0] ip_wdata,
  output logic [AW-1:0] ip_rdata,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_addr,
  input  logic [AW-1:0] d_addr,
  input  logic          d_rd,
  input  logic          d_wr,
  input  logic [DW-1:0] d_wdata,
  output logic [DW-1:0] d_rdata,
  output logic          d_rvalid,
  output logic          d_conflict,
  output logic [FW-1:0] flash_addr,
  output logic          flash_en,
  input  logic [DW-1:0] flash_rdata,
  output logic [RW-1:0] rom_addr,
  output logic          rom_en,
  input  logic [DW-1:0] rom_rdata,
  output logic [SW-1:0] sram_addr,
  output logic          sram_en,
  output logic          sram_we,
  output logic [DW-1:0] sram_wdata,
  input  logic [DW-1:0] sram_rdata
);
  logic [1:0]    rst_sync;
  logic          rst_q_n;
  logic [AW-1:0] ip, f_off, d_off;
  seg_e          f_seg, d_seg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  hfm_ip #(.AW(AW), .RESET_IP(RESET_IP)) ip_i (
    .clk(clk), .rst_n(rst_q_n), .adv(fetch_req), .redir(redir_valid),
    .redir_addr(redir_addr), .sw_we(ip_we), .sw_data(ip_wdata), .ip(ip)
  );

  hfm_decode #(
    .AW(AW), .FLASH_BASE('0), .FLASH_WORDS(FLASH_WORDS),
    .ROM_BASE(P_ROM_BASE), .ROM_WORDS(ROM_WORDS),
    .SRAM_BASE(P_SRAM_BASE), .SRAM_WORDS(SRAM_WORDS)
  ) pdec_i (.addr(ip), .seg(f_seg), .off(f_off));

  hfm_decode #(
    .AW(AW), .FLASH_BASE(D_FLASH_BASE), .FLASH_WORDS(FLASH_WORDS),
    .ROM_BASE(D_ROM_BASE), .ROM_WORDS(ROM_WORDS),
    .SRAM_BASE(D_SRAM_BASE), .SRAM_WORDS(SRAM_WORDS)
  ) ddec_i (.addr(d_addr), .seg(d_seg), .off(d_off));

  hfm_route #(.AW(AW), .DW(DW), .FW(FW), .RW(RW), .SW(SW)) route_i (
    .clk(clk), .rst_n(rst_q_n),
    .f_req(fetch_req), .f_seg(f_seg), .f_off(f_off),
    .d_rd(d_rd), .d_wr(d_wr), .d_seg(d_seg), .d_off(d_off), .d_wdata(d_wdata),
    .flash_addr(flash_addr), .flash_en(flash_en), .flash_rdata(flash_rdata),
    .rom_addr(rom_addr), .rom_en(rom_en), .rom_rdata(rom_rdata),
    .sram_addr(sram_addr), .sram_en(sram_en), .sram_we(sram_we),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
    .d_rvalid(d_rvalid), .d_rdata(d_rdata), .d_conflict(d_conflict)
  );

  assign ip_rdata = ip;
endmodule

// File: rtl/hfm_checker.sv
module hfm_checker
  import hfm_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_req,
  input logic          fetch_valid,
  input logic          ip_we,
  input logic [AW-1:0] ip_wdata,
  input logic [AW-1:0] ip_rdata,
  input logic          redir_valid,
  input logic [AW-1:0] redir_addr,
  input logic          d_rd,
  input logic          d_wr,
  input logic [DW-1:0] d_rdata,
  input logic          d_conflict,
  input logic          sram_we,
  input logic          flash_en,
  input seg_e          f_seg,
  input seg_e          d_seg
);
  // R2
  fetch_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $past(fetch_req));

  // R2
  ip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !redir_valid && !ip_we) |=> ip_rdata == $past(ip_rdata) + 1'b1);

  // R3
  redir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> ip_rdata == $past(redir_addr));

  // R3
  sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_we && !redir_valid) |=> ip_rdata == $past(ip_wdata));

  // R7
  conflict_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_conflict |-> d_rdata == '0);

  // R7
  conflict_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    d_conflict |-> $past(d_rd || d_wr));

  // R7
  own_seg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((d_rd || d_wr) && d_seg != SEG_NONE && d_seg == f_seg) |=> d_conflict);

  // R8
  sram_write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (d_wr && d_seg == SEG_SRAM));

  // R8
  flash_no_dwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_wr && !d_rd && f_seg != SEG_FLASH) |-> !flash_en);

  // R9
  sram_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && f_seg == SEG_SRAM) |-> !sram_we);
endmodule

bind harvard_fetch_map hfm_checker #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_q_n), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
  .ip_we(ip_we), .ip_wdata(ip_wdata), .ip_rdata(ip_rdata),
  .redir_valid(redir_valid), .redir_addr(redir_addr),
  .d_rd(d_rd), .d_wr(d_wr), .d_rdata(d_rdata), .d_conflict(d_conflict),
  .sram_we(sram_we), .flash_en(flash_en), .f_seg(f_seg), .d_seg(d_seg)
);

// File: tb/harvard_fetch_map_tb.sv
`timescale 1ns/1ps
module harvard_fetch_map_tb_top;
  logic        clk, rst_n;
  logic        fetch_req, fetch_valid, ip_we, redir_valid, d_rd, d_wr, d_rvalid, d_conflict;
  logic [15:0] fetch_instr, ip_wdata, ip_rdata, redir_addr, d_addr, d_wdata, d_rdata;
  logic [13:0] flash_addr;
  logic [11:0] rom_addr;
  logic [10:0] sram_addr;
  logic        flash_en, rom_en, sram_en, sram_we;
  logic [15:0] sram_wdata, flash_q, rom_q, sram_q;
  logic [15:0] sram_mem [2048];
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  harvard_fetch_map dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_valid(fetch_valid),
    .fetch_instr(fetch_instr), .ip_we(ip_we), .ip_wdata(ip_wdata), .ip_rdata(ip_rdata),
    .redir_valid(redir_valid), .redir_addr(redir_addr), .d_addr(d_addr), .d_rd(d_rd),
    .d_wr(d_wr), .d_wdata(d_wdata), .d_rdata(d_rdata), .d_rvalid(d_rvalid),
    .d_conflict(d_conflict), .flash_addr(flash_addr), .flash_en(flash_en),
    .flash_rdata(flash_q), .rom_addr(rom_addr), .rom_en(rom_en), .rom_rdata(rom_q),
    .sram_addr(sram_addr), .sram_en(sram_en), .sram_we(sram_we),
    .sram_wdata(sram_wdata), .sram_rdata(sram_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Memory models with one-cycle latency: flash word = {01,addr}, ROM word = {B,addr}
  always_ff @(posedge clk) begin
    if (flash_en) flash_q <= {2'b01, flash_addr};
    if (rom_en)   rom_q   <= {4'hB, rom_addr};
    if (sram_en) begin
      if (sram_we) sram_mem[sram_addr] <= sram_wdata;
      else         sram_q <= sram_mem[sram_addr];
    end
  end

  typedef struct packed {
    logic fr; logic rv; logic [15:0] ra; logic iw; logic [15:0] iwd;
    logic drd; logic dwr; logic [15:0] da; logic [15:0] dwd;
    logic efv; logic [15:0] efi; logic edv; logic [15:0] edr; logic ecf; logic [15:0] eip;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0000,16'h0000, 1'b1,16'hB000,1'b0,16'h0000,1'b0,16'h8001},
    '{1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h4005,16'h0000, 1'b1,16'hB001,1'b1,16'h4005,1'b0,16'h8002},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1,16'h0010,16'h1234, 1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h8002},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h8003,16'h0000, 1'b0,16'h0000,1'b1,16'h0000,1'b1,16'h8002},
    '{1'b1,1'b1,16'hA000,1'b0,16'h0000,1'b0,1'b0,16'h0000,16'h0000, 1'b1,16'hB002,1'b0,16'h0000,1'b0,16'hA000},
    '{1'b1,1'b0,16'h0000,1'b1,16'h0010,1'b1,1'b0,16'h0010,16'h0000, 1'b1,16'h5000,1'b1,16'h0000,1'b1,16'h0010},
    '{1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0010,16'h0000, 1'b1,16'h4010,1'b1,16'h1234,1'b0,16'h0011},
    '{1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h4000,16'h0000, 1'b1,16'h4011,1'b1,16'h0000,1'b1,16'h0012},
    '{1'b0,1'b1,16'hA000,1'b0,16'h0000,1'b0,1'b0,16'h0000,16'h0000, 1'b0,16'h0000,1'b0,16'h0000,1'b0,16'hA000},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b1,16'h0010,16'hBEEF, 1'b0,16'h0000,1'b0,16'h0000,1'b1,16'hA000},
    '{1'b0,1'b1,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0000,16'h0000, 1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h0000},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0010,16'h0000, 1'b0,16'h0000,1'b1,16'h1234,1'b0,16'h0000},
    '{1'b0,1'b1,16'h9000,1'b0,16'h0000,1'b0,1'b0,16'h0000,16'h0000, 1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h9000},
    '{1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h4002,16'h0000, 1'b1,16'h0000,1'b1,16'h4002,1'b0,16'h9001},
    '{1'b0,1'b1,16'h8000,1'b1,16'h1234,1'b0,1'b0,16'h0000,16'h0000, 1'b0,16'h0000,1'b0,16'h0000,1'b0,16'h8000},
    '{1'b1,1'b0,16'h0000,1'b1,16'h3FFF,1'b0,1'b0,16'h0000,16'h0000, 1'b1,16'hB000,1'b0,16'h0000,1'b0,16'h3FFF},
    '{1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b0,1'b0,16'h0000,16'h0000, 1'b1,16'h7FFF,1'b0,16'h0000,1'b0,16'h4000},
    '{1'b1,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h9000,16'h0000, 1'b1,16'h0000,1'b1,16'h0000,1'b0,16'h4001},
    '{1'b0,1'b0,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h8001,16'h0000, 1'b0,16'h0000,1'b1,16'hB001,1'b0,16'h4001}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    fetch_req = 0; redir_valid = 0; redir_addr = '0; ip_we = 0; ip_wdata = '0;
    d_rd = 0; d_wr = 0; d_addr = '0; d_wdata = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2048; i++) sram_mem[i] = 16'h5000 | 16'(i);
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: pointer value while reset is held
    chk("R1 ip in reset", ip_rdata, 16'h8000);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 ip after release", ip_rdata, 16'h8000);
    chk("R1 fetch_valid", {15'd0, fetch_valid}, 16'd0);
    chk("R1 d_rvalid", {15'd0, d_rvalid}, 16'd0);
    chk("R1 d_conflict", {15'd0, d_conflict}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      fetch_req = VECS[i].fr; redir_valid = VECS[i].rv; redir_addr = VECS[i].ra;
      ip_we = VECS[i].iw; ip_wdata = VECS[i].iwd; d_rd = VECS[i].drd;
      d_wr = VECS[i].dwr; d_addr = VECS[i].da; d_wdata = VECS[i].dwd;
      @(posedge clk);
      @(negedge clk);
      chk("R2 fetch_valid", {15'd0, fetch_valid}, {15'd0, VECS[i].efv});
      if (VECS[i].efv) chk("R5 fetch_instr", fetch_instr, VECS[i].efi);
      chk("R6 d_rvalid", {15'd0, d_rvalid}, {15'd0, VECS[i].edv});
      if (VECS[i].edv) chk("R6 d_rdata", d_rdata, VECS[i].edr);
      chk("R7 d_conflict", {15'd0, d_conflict}, {15'd0, VECS[i].ecf});
      chk("R4 ip_rdata", ip_rdata, VECS[i].eip);
    end
    idle();

    // R3: redirect and software write together, redirect wins
    redir_valid = 1; redir_addr = 16'h0100; ip_we = 1; ip_wdata = 16'h0200; fetch_req = 1;
    @(negedge clk);
    idle();
    chk("R3 redirect priority", ip_rdata, 16'h0100);
    fetch_req = 1;
    @(negedge clk);
    idle();
    chk("R3 next fetch at loaded value", fetch_instr, 16'h4100);

    // R8: data write into flash window (executing flash at 0101h... move to unmapped first)
    redir_valid = 1; redir_addr = 16'hF000;
    @(negedge clk);
    idle();
    d_wr = 1; d_addr = 16'h4003; d_wdata = 16'hAAAA;
    #1;
    chk("R8 no sram_we on flash write", {15'd0, sram_we}, 16'd0);
    chk("R8 no flash_en on flash write", {15'd0, flash_en}, 16'd0);
    d_addr = 16'h8002;
    #1;
    chk("R8 no sram_we on rom write", {15'd0, sram_we}, 16'd0);
    @(negedge clk);
    idle();
    chk("R8 no conflict outside exec", {15'd0, d_conflict}, 16'd0);

    // R9: fetch owns SRAM, data read of SRAM loses the port
    redir_valid = 1; redir_addr = 16'hA004;
    @(negedge clk);
    idle();
    fetch_req = 1; d_rd = 1; d_addr = 16'h0007;
    #1;
    chk("R9 sram port carries fetch addr", {5'd0, sram_addr}, 16'h0004);
    @(negedge clk);
    idle();
    chk("R9 fetch word from sram", fetch_instr, 16'h5004);
    chk("R9 data side flagged", {15'd0, d_conflict}, 16'd1);
    @(negedge clk);
    chk("R7 flag lasts one cycle", {15'd0, d_conflict}, 16'd0);

    // R1: asynchronous reset mid-run
    rst_n = 0;
    #1;
    chk("R1 async reset ip", ip_rdata, 16'h8000);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 fetch_valid after reset", {15'd0, fetch_valid}, 16'd0);

    finish_run();
  end
endmodule